// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is a passive slave port through which an external host reads and writes 16-bit words held inside the device. The host bus can be 8 or 16 bits wide. The host can drive it with either of two strobe styles: a separate read strobe and write strobe, or a single data strobe qualified by a direction line. All host pins are asynchronous to the internal clock. Each pin passes through a synchronizer, and a transfer takes effect one cycle after the synchronized strobe ends.

Data moves through two holding registers. The inbound register collects words the host writes and raises `in_full`. The device side clears that flag with `in_take`. The outbound register is loaded by the device side through `out_load`, which raises `out_full`. A completed host read of that register clears the flag. On the 16-bit bus the two bytes can be exchanged in both directions. On the 8-bit bus a word-wide logical mode moves one byte per access and uses a host byte-select pin. A narrow logical mode moves only the low byte. A second host address returns both flags.

Top module: `hpb_host_port`

## Requirements
- R1: After reset `in_full`=0, `out_full`=0, `in_word`=0, `h_doe`=0 and `h_dout`=0.
- R2: With `cfg_bus16`=1, a host data write (`h_addr`=0) stores `h_din` into `in_word` unchanged when `cfg_swap`=0, or with bits [15:8] and [7:0] exchanged when `cfg_swap`=1, and sets `in_full`.
- R3: With `cfg_bus16`=1, a host data read drives the outbound word on `h_dout`, with bytes exchanged when `cfg_swap`=1. Completing the read clears `out_full`.
- R4: With `cfg_bus16`=0 and `cfg_log16`=1, a data write with `h_bsel`=1 stages `h_din[7:0]` as the high byte and leaves `in_full` and `in_word` unchanged. A data write with `h_bsel`=0 stores {staged byte, `h_din[7:0]`} and sets `in_full`. The staged byte is 0 after reset.
- R5: With `cfg_bus16`=0 and `cfg_log16`=1, a data read returns the outbound high byte on `h_dout[7:0]` when `h_bsel`=1 and the low byte when `h_bsel`=0, with `h_dout[15:8]`=0. Only completing a low-byte read clears `out_full`.
- R6: With `cfg_bus16`=0 and `cfg_log16`=0, a data write stores {8'h00, `h_din[7:0]`} and sets `in_full`. A data read returns {8'h00, outbound low byte} and clears `out_full` when it completes. `h_bsel` and `cfg_swap` have no effect.
- R7: With `cfg_dstrb`=0, a read is `h_stb_n`=0 and a write is `h_wrn_rw`=0, both active low. With `cfg_dstrb`=1, `h_stb_n`=0 is the data strobe and `h_wrn_rw` gives the direction (1 read, 0 write). Every access also needs `h_cs_n`=0.
- R8: A transfer takes effect on the trailing edge of the strobe. While the strobe is held, `in_word`, `in_full` and `out_full` do not change because of it.
- R9: Address 1 is the status word: bit0 = `in_full`, bit1 = `out_full`, other bits 0, never swapped. Reading it clears no flag. Writing it changes nothing.
- R10: `in_take` clears `in_full`, and `out_load` loads `out_word` and sets `out_full`. If a host commit falls in the same cycle, setting wins: a word completed together with `in_take` leaves `in_full`=1, and `out_load` together with a completed read leaves `out_full`=1 holding the new word.
- R11: With `h_cs_n`=1, strobes are ignored. `h_doe` is 1 only while a read is being strobed with the port selected, and `h_dout` is 0 whenever `h_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus16 | input | 1 | 1: 16-bit host bus, 0: 8-bit host bus |
| cfg_swap | input | 1 | Exchange bytes on the 16-bit bus |
| cfg_log16 | input | 1 | Word-wide logical mode on the 8-bit bus |
| cfg_dstrb | input | 1 | 0: separate read/write strobes, 1: data strobe plus direction |
| h_cs_n | input | 1 | Host chip select, active low |
| h_addr | input | 1 | 0: data register, 1: status word |
| h_bsel | input | 1 | Byte select in word-wide 8-bit mode, 1 = high |
| h_stb_n | input | 1 | Read strobe or data strobe, active low |
| h_wrn_rw | input | 1 | Write strobe (active low) or direction (1 = read) |
| h_din | input | 16 | Host write data |
| h_dout | output | 16 | Host read data |
| h_doe | output | 1 | Host read data enable |
| in_word | output | 16 | Inbound word written by the host |
| in_full | output | 1 | Inbound word waiting |
| in_take | input | 1 | Device side consumed the inbound word |
| out_word | input | 16 | Word to offer to the host |
| out_load | input | 1 | Load `out_word` into the outbound register |
| out_full | output | 1 | Outbound word not yet read by the host |

## Verification
The hardest case to reach is a device-side action in the exact cycle when a host commit is applied (R10). That cycle lies a fixed number of synchronizer stages after the strobe is released, and the host pins give no sign of it. The bench releases the strobe on a falling clock edge and counts the synchronizer depth in rising edges. It then raises `in_take` or `out_load` for exactly the commit edge and checks that the setting side wins. Randomized sequences also switch bus width, logical mode, swap and strobe style between accesses, so that staged high bytes carry across modes.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

   // Access attributes captured while a host strobe is active
   typedef struct packed {
      logic is_wr;
      logic addr;
      logic bsel;
   } hpb_acc_t;

   // Exchange the two halves of a word
   function automatic logic [15:0] hpb_swap16(input logic [15:0] w);
      return {w[7:0], w[15:8]};
   endfunction

endpackage

// File: rtl/hpb_strobe_sync.sv
module hpb_strobe_sync
   import hpb_pkg::*;
#(
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_dstrb,
   input  logic          h_cs_n,
   input  logic          h_stb_n,
   input  logic          h_wrn_rw,
   input  logic          h_addr,
   input  logic          h_bsel,
   input  logic [DW-1:0] h_din,
   output logic          done,
   output hpb_acc_t      done_acc,
   output logic [DW-1:0] done_data
);
   localparam int NCTL = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hpb_strobe_sync: SYNC_STAGES must be at least 2");
   end

   logic [NCTL-1:0] raw;
   logic [NCTL-1:0] stage_q [SYNC_STAGES];
   assign raw = {h_cs_n, h_stb_n, h_wrn_rw};

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '1;
         else if (s == 0) stage_q[s] <= raw;
         else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   logic cs_s, stb_s, aux_s;
   assign cs_s  = ~stage_q[SYNC_STAGES-1][2];
   assign stb_s = ~stage_q[SYNC_STAGES-1][1];
   assign aux_s =  stage_q[SYNC_STAGES-1][0];

   logic act, act_wr;
   always_comb begin
      if (cfg_dstrb) begin
         act    = cs_s & stb_s;
         act_wr = ~aux_s;
      end else begin
         act    = cs_s & (stb_s | ~aux_s);
         act_wr = ~aux_s;
      end
   end

   logic act_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         done_acc  <= '0;
         done_data <= '0;
      end else begin
         act_q <= act;
         if (act) begin
            done_acc  <= '{is_wr: act_wr, addr: h_addr, bsel: h_bsel};
            done_data <= h_din;
         end
      end
   end

   assign done = act_q & ~act;

endmodule

// File: rtl/hpb_wr_path.sv
module hpb_wr_path
   import hpb_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_bus16,
   input  logic          cfg_swap,
   input  logic          cfg_log16,
   input  logic          done,
   input  hpb_acc_t      done_acc,
   input  logic [DW-1:0] done_data,
   input  logic          in_take,
   output logic [DW-1:0] in_word,
   output logic          in_full
);
   localparam int BW = DW / 2;

   if (DW != 16) begin : g_bad_dw
      $error("hpb_wr_path: DW must be 16");
   end

   logic data_wr, word_commit, hi_stage;
   logic [BW-1:0] hi_q;
   logic [DW-1:0] next_word;

   assign data_wr     = done & done_acc.is_wr & ~done_acc.addr;
   assign word_commit = data_wr & (cfg_bus16 | ~cfg_log16 | ~done_acc.bsel);
   assign hi_stage    = data_wr & ~cfg_bus16 & cfg_log16 & done_acc.bsel;

   always_comb begin
      if (cfg_bus16)
         next_word = cfg_swap ? hpb_swap16(done_data) : done_data;
      else if (cfg_log16)
         next_word = {hi_q, done_data[BW-1:0]};
      else
         next_word = {{BW{1'b0}}, done_data[BW-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         in_word <= '0;
         in_full <= 1'b0;
      end else begin
         if (hi_stage) hi_q <= done_data[BW-1:0];
         if (word_commit) begin
            in_word <= next_word;
            in_full <= 1'b1;
         end else if (in_take) begin
            in_full <= 1'b0;
         end
      end
   end

   assert_commit_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_commit |=> in_full);
   assert_full_rise_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_full) |-> $past(word_commit));
   assert_stage_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_stage && !in_take) |=> $stable(in_full));

endmodule

// File: rtl/hpb_rd_path.sv
module hpb_rd_path
   import hpb_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_bus16,
   input  logic          cfg_swap,
   input  logic          cfg_log16,
   input  logic          done,
   input  hpb_acc_t      done_acc,
   input  logic          h_addr,
   input  logic          h_bsel,
   input  logic          h_doe,
   input  logic          in_full,
   input  logic [DW-1:0] out_word,
   input  logic          out_load,
   output logic          out_full,
   output logic [DW-1:0] h_dout
);
   localparam int BW = DW / 2;

   logic rd_complete;
   logic [DW-1:0] out_q, mux;

   assign rd_complete = done & ~done_acc.is_wr & ~done_acc.addr &
                        (cfg_bus16 | ~cfg_log16 | ~done_acc.bsel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q    <= '0;
         out_full <= 1'b0;
      end else if (out_load) begin
         out_q    <= out_word;
         out_full <= 1'b1;
      end else if (rd_complete) begin
         out_full <= 1'b0;
      end
   end

   always_comb begin
      if (h_addr)
         mux = {{(DW-2){1'b0}}, out_full, in_full};
      else if (cfg_bus16)
         mux = cfg_swap ? hpb_swap16(out_q) : out_q;
      else if (cfg_log16 && h_bsel)
         mux = {{BW{1'b0}}, out_q[DW-1:BW]};
      else
         mux = {{BW{1'b0}}, out_q[BW-1:0]};
   end

   assign h_dout = h_doe ? mux : '0;

   assert_load_sets_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_load |=> out_full);
   assert_clear_only_by_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_full) |-> $past(rd_complete));

endmodule

// File: rtl/hpb_host_port.sv
module hpb_host_port
   import hpb_pkg::*;
#(
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_bus16,
   input  logic          cfg_swap,
   input  logic          cfg_log16,
   input  logic          cfg_dstrb,
   input  logic          h_cs_n,
   input  logic          h_addr,
   input  logic          h_bsel,
   input  logic          h_stb_n,
   input  logic          h_wrn_rw,
   input  logic [DW-1:0] h_din,
   output logic [DW-1:0] h_dout,
   output logic          h_doe,
   output logic [DW-1:0] in_word,
   output logic          in_full,
   input  logic          in_take,
   input  logic [DW-1:0] out_word,
   input  logic          out_load,
   output logic          out_full
);
   logic     done;
   hpb_acc_t done_acc;
   logic [DW-1:0] done_data;

   // Read enable follows the raw pins so data appears within the host strobe
   assign h_doe = ~h_cs_n & ~h_stb_n & (cfg_dstrb ? h_wrn_rw : 1'b1);

   hpb_strobe_sync #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cfg_dstrb(cfg_dstrb),
      .h_cs_n(h_cs_n), .h_stb_n(h_stb_n), .h_wrn_rw(h_wrn_rw),
      .h_addr(h_addr), .h_bsel(h_bsel), .h_din(h_din),
      .done(done), .done_acc(done_acc), .done_data(done_data)
   );

   hpb_wr_path #(.DW(DW)) u_wr (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_swap(cfg_swap),
      .cfg_log16(cfg_log16), .done(done), .done_acc(done_acc),
      .done_data(done_data), .in_take(in_take),
      .in_word(in_word), .in_full(in_full)
   );

   hpb_rd_path #(.DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_swap(cfg_swap),
      .cfg_log16(cfg_log16), .done(done), .done_acc(done_acc),
      .h_addr(h_addr), .h_bsel(h_bsel), .h_doe(h_doe), .in_full(in_full),
      .out_word(out_word), .out_load(out_load),
      .out_full(out_full), .h_dout(h_dout)
   );

   assert_deselect_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      h_cs_n |-> (!h_doe && h_dout == '0));

endmodule

// File: tb/tb_hpb_host_port.sv
module tb_hpb_host_port;
   localparam int SYNC = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_bus16 = 1, cfg_swap = 0, cfg_log16 = 1, cfg_dstrb = 0;
   logic h_cs_n = 1, h_addr = 0, h_bsel = 0, h_stb_n = 1, h_wrn_rw = 1;
   logic [15:0] h_din = '0, h_dout, in_word, out_word = '0;
   logic h_doe, in_full, in_take = 0, out_load = 0, out_full;

   int total = 0, bad = 0;
   logic [15:0] m_in = '0, m_out = '0;
   logic [7:0]  m_hi = '0;
   logic        m_inf = 0, m_outf = 0;

   always #2.5 clk = ~clk;

   hpb_host_port dut (.*);

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic completes(logic sel);
      return cfg_bus16 | ~cfg_log16 | ~sel;
   endfunction

   function automatic logic [15:0] f_wr_word(logic [15:0] d);
      if (cfg_bus16) return cfg_swap ? {d[7:0], d[15:8]} : d;
      if (cfg_log16) return {m_hi, d[7:0]};
      return {8'h00, d[7:0]};
   endfunction

   function automatic logic [15:0] f_rd(logic a, logic sel);
      if (a) return {14'b0, m_outf, m_inf};
      if (cfg_bus16) return cfg_swap ? {m_out[7:0], m_out[15:8]} : m_out;
      if (cfg_log16 && sel) return {8'h00, m_out[15:8]};
      return {8'h00, m_out[7:0]};
   endfunction

   // Drive one host access; release_hook: 0 none, 1 pulse in_take, 2 pulse out_load at commit
   task automatic host(bit wr, bit a, bit sel, logic [15:0] d, int hook, logic [15:0] ld);
      logic [15:0] exp;
      exp = f_rd(a, sel);
      @(negedge clk);
      h_cs_n = 0; h_addr = a; h_bsel = sel; h_din = d;
      if (cfg_dstrb) h_wrn_rw = ~wr;
      @(negedge clk);
      if (cfg_dstrb || !wr) h_stb_n = 0; else h_wrn_rw = 0;
      repeat (4) @(negedge clk);
      if (!wr) begin
         chk("R7 doe during read", {15'b0, h_doe}, 16'h1);
         chk(a ? "R9 status read" : (cfg_bus16 ? "R3 read data" : (cfg_log16 ? "R5 read byte" : "R6 read low")), h_dout, exp);
      end
      chk("R8 held strobe no commit", {14'b0, in_full, out_full}, {14'b0, m_inf, m_outf});
      h_stb_n = 1;
      if (!cfg_dstrb) h_wrn_rw = 1;
      if (hook != 0) begin
         repeat (SYNC) @(posedge clk);
         @(negedge clk);
         if (hook == 1) in_take = 1; else begin out_load = 1; out_word = ld; end
         @(negedge clk);
         in_take = 0; out_load = 0;
      end
      repeat (SYNC + 3) @(negedge clk);
      h_cs_n = 1;
      if (cfg_dstrb) h_wrn_rw = 1;
      // model
      if (wr && !a) begin
         if (completes(sel)) begin m_in = f_wr_word(d); m_inf = 1; end
         else m_hi = d[7:0];
      end
      if (!wr && !a && completes(sel)) m_outf = 0;
      if (hook == 1 && !(wr && !a && completes(sel))) m_inf = 0;
      if (hook == 2) begin m_out = ld; m_outf = 1; end
   endtask

   task automatic dev_load(logic [15:0] v);
      @(negedge clk); out_word = v; out_load = 1;
      @(negedge clk); out_load = 0;
      m_out = v; m_outf = 1;
   endtask

   task automatic dev_take();
      @(negedge clk); in_take = 1;
      @(negedge clk); in_take = 0;
      m_inf = 0;
   endtask

   task automatic check_state(string req);
      @(negedge clk);
      chk(req, in_word, m_in);
      chk(req, {14'b0, in_full, out_full}, {14'b0, m_inf, m_outf});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 in_word", in_word, 16'h0);
      chk("R1 flags/doe", {13'b0, in_full, out_full, h_doe}, 16'h0);
      chk("R1 dout", h_dout, 16'h0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2 16-bit write, plain and swapped
      cfg_bus16 = 1; cfg_swap = 0; cfg_dstrb = 0;
      host(1, 0, 0, 16'hA1B2, 0, 0); check_state("R2 plain write");
      dev_take(); check_state("R10 take clears");
      cfg_swap = 1;
      host(1, 0, 0, 16'hC3D4, 0, 0); check_state("R2 swapped write");
      chk("R2 swap value", in_word, 16'hD4C3);
      // R3 16-bit read swapped and plain
      dev_load(16'h1357); check_state("R10 load sets");
      host(0, 0, 0, 0, 0, 0); check_state("R3 read clears");
      cfg_swap = 0; dev_load(16'h2468);
      host(0, 0, 0, 0, 0, 0); check_state("R3 plain read clears");
      // R9 status read and write
      dev_load(16'h0F0F);
      host(0, 1, 0, 0, 0, 0); check_state("R9 status read keeps flags");
      host(1, 1, 0, 16'hFFFF, 0, 0); check_state("R9 status write ignored");
      dev_take();

      // R4/R5 8-bit word mode with data strobe style (R7)
      cfg_bus16 = 0; cfg_log16 = 1; cfg_dstrb = 1;
      host(1, 0, 1, 16'h99AB, 0, 0); check_state("R4 high stage no flag");
      host(1, 0, 0, 16'h77CD, 0, 0); check_state("R4 low completes");
      chk("R4 word", in_word, 16'hABCD);
      dev_load(16'hBEEF);
      host(0, 0, 1, 0, 0, 0); check_state("R5 high read keeps flag");
      host(0, 0, 0, 0, 0, 0); check_state("R5 low read clears");
      // R6 8-bit narrow mode
      cfg_log16 = 0; cfg_swap = 1;
      host(1, 0, 1, 16'h5566, 0, 0); check_state("R6 narrow write");
      chk("R6 word", in_word, 16'h0066);
      dev_load(16'hCAFE);
      host(0, 0, 1, 0, 0, 0); check_state("R6 narrow read clears");

      // R11 deselected strobes ignored
      dev_take();
      @(negedge clk); h_stb_n = 0; h_wrn_rw = 0; h_din = 16'h4242;
      repeat (3) @(negedge clk);
      chk("R11 doe deselected", {15'b0, h_doe}, 16'h0);
      chk("R11 dout deselected", h_dout, 16'h0);
      h_stb_n = 1; h_wrn_rw = 1;
      check_state("R11 no transfer");

      // R10 collisions at the commit cycle
      cfg_bus16 = 1; cfg_swap = 0; cfg_dstrb = 0;
      host(1, 0, 0, 16'h1111, 1, 0); check_state("R10 commit beats take");
      chk("R10 full kept", {15'b0, in_full}, 16'h1);
      dev_load(16'h2222);
      host(0, 0, 0, 0, 2, 16'h3333); check_state("R10 load beats read clear");
      chk("R10 out kept", {15'b0, out_full}, 16'h1);
      host(0, 0, 0, 0, 0, 0); check_state("R10 new word readback");

      // Randomized sequences
      for (int i = 0; i < 300; i++) begin
         int op;
         if (i % 20 == 0) begin
            @(negedge clk);
            {cfg_bus16, cfg_swap, cfg_log16, cfg_dstrb} = 4'($urandom);
         end
         op = $urandom_range(0, 5);
         case (op)
            0: host(1, 0, 1'($urandom), 16'($urandom), 0, 0);
            1: host(0, 0, 1'($urandom), 0, 0, 0);
            2: host(0, 1, 1'($urandom), 0, 0, 0);
            3: host(1, 1, 1'($urandom), 16'($urandom), 0, 0);
            4: dev_load(16'($urandom));
            default: dev_take();
         endcase
         check_state("R2 R4 R6 R9 R10 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule